// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block sequences the conversions of a successive-approximation converter. It sits on a small register write port and holds two registers. The control register carries the unit enable, the start/busy bit, the auto-trigger enable, the done flag, the interrupt enable and a clock-divider field. The channel register holds the multiplexer code. The bench-visible copies of both registers are brought out as plain outputs so that a separate read-path block can format and return them.

A conversion is started in one of two ways: software writes a 1 to the start bit, or a trigger input arrives while auto-triggering is on. The block then announces the start with a one-cycle trigger-out pulse that carries the channel code. It counts a fixed number of converter clock periods, each period being a power-of-two multiple of the system clock. At the end it captures the digital sample input as the result, pulses `done`, sets the flag and drops the start bit. The first conversion after each enable is longer. Turning the unit off abandons any conversion in progress.

Top module: `adc_seq_ctrl`

## Requirements
- R1: A write to the control register that leaves the unit enabled cannot clear the start bit while a conversion runs. The bit stays 1 until the conversion completes.
- R2: Writing the enable bit to 0 clears the start bit on the next cycle and abandons the running conversion: no `done` pulse follows and the flag is not set. This holds even when the disabling write lands on the completion cycle.
- R3: The converter clock period is 2^max(P,1) system clocks, where P is the 3-bit divider field (control bits 2:0). A conversion holds the start bit high for exactly (periods × 2^max(P,1)) cycles.
- R4: The first conversion after the enable bit goes from 0 to 1 lasts 25 periods. Later conversions last 13 periods. Each new 0-to-1 change of enable makes the next conversion a first one again.
- R5: At completion, `done` is high for one cycle, the start bit (control bit 6) is 0, the flag (control bit 4) is 1, and `result` holds the value of `sample_in` from the completion edge.
- R6: While enabled and idle with auto-trigger (control bit 5) set, a cycle with `trig_in` high starts a conversion. With auto-trigger clear, `trig_in` has no effect.
- R7: When the start bit goes from 0 to 1, `trig_out` is high for exactly one cycle, in the first cycle the start bit is high. During that cycle `trig_chan` equals the channel register (address 1, bits 3:0).
- R8: The flag is cleared by writing 1 to control bit 4 or by pulsing `irq_ack`. If a completion falls in the same cycle, the flag is set instead. `irq` is high exactly when the flag and the interrupt enable (control bit 3) are both 1.
- R9: A control write with enable (bit 7) at 0 leaves the start bit at 0, even if the written start bit is 1.
- R10: A synchronous reset clears both registers, `trig_out`, `done` and `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = control register, 1 = channel register |
| wr_data | input | 8 | Write data |
| trig_in | input | 1 | External conversion trigger |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| sample_in | input | SAMPLE_W | Digital sample captured at completion |
| ctrl_o | output | 8 | Control register: 7 enable, 6 start, 5 auto-trigger, 4 flag, 3 interrupt enable, 2:0 divider |
| chan_o | output | 4 | Channel register |
| trig_out | output | 1 | One-cycle pulse at conversion start |
| trig_chan | output | 4 | Channel code carried with the trigger-out pulse |
| done | output | 1 | One-cycle completion pulse |
| result | output | SAMPLE_W | Captured sample |
| irq | output | 1 | Interrupt request |

## Verification
A software write to the control register can land on the same edge as the end of a conversion. This case is provoked twice. The bench starts a conversion of known length and times the write so that it arrives on the completion edge. In the first run the write clears the flag and keeps the unit enabled: the flag must read 1, `done` must pulse and the start bit must fall. In the second run the write disables the unit: `done` must stay low and the flag must stay 0.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int PSC_W     = 3;
    localparam int CHAN_W    = 4;
    localparam int REG_W     = 8;
    localparam int LONG_LEN  = 25;
    localparam int SHORT_LEN = 13;
    localparam int MAX_SHIFT = (1 << PSC_W) - 1;
    localparam int CNT_W     = $clog2(LONG_LEN << MAX_SHIFT) + 1;

    typedef struct packed {
        logic             en;
        logic             start;
        logic             auto_trig;
        logic             flag;
        logic             ie;
        logic [PSC_W-1:0] psc;
    } ctrl_t;

    // Conversion length in system clocks; a divider field of 0 acts as 1.
    function automatic logic [CNT_W-1:0] conv_cycles(input logic long_conv,
                                                      input logic [PSC_W-1:0] psc);
        int sh;
        int len;
        sh  = (psc == '0) ? 1 : int'(psc);
        len = long_conv ? LONG_LEN : SHORT_LEN;
        return CNT_W'(len << sh);
    endfunction

endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              trig_in,
    input  logic              irq_ack,
    input  logic              conv_last,
    output ctrl_t             ctrl_q,
    output logic [CHAN_W-1:0] chan_q,
    output logic              start_go,
    output logic              complete,
    output logic              keep_run,
    output logic              long_conv,
    output logic [PSC_W-1:0]  psc_next
);

    ctrl_t             nxt;
    ctrl_t             wd;
    logic [CHAN_W-1:0] chan_n;
    logic              first_q, first_n;
    logic              wr_c, wr_m, req, en_rise;

    always_comb begin
        wd      = ctrl_t'(wr_data);
        wr_c    = wr_en && !wr_addr;
        wr_m    = wr_en && wr_addr;
        nxt     = ctrl_q;
        chan_n  = chan_q;
        if (wr_c) begin
            nxt.en        = wd.en;
            nxt.auto_trig = wd.auto_trig;
            nxt.ie        = wd.ie;
            nxt.psc       = wd.psc;
        end
        if (wr_m) chan_n = wr_data[CHAN_W-1:0];

        en_rise  = !ctrl_q.en && nxt.en;
        complete = conv_last && nxt.en;
        req      = (wr_c && wd.start) || (ctrl_q.auto_trig && trig_in);

        if (!nxt.en)           nxt.start = 1'b0;
        else if (ctrl_q.start) nxt.start = !complete;
        else                   nxt.start = req;

        start_go  = !ctrl_q.start && nxt.start;
        long_conv = first_q || en_rise;

        if (complete)                          nxt.flag = 1'b1;
        else if (irq_ack || (wr_c && wd.flag)) nxt.flag = 1'b0;

        if (start_go)     first_n = 1'b0;
        else if (en_rise) first_n = 1'b1;
        else              first_n = first_q;

        keep_run = nxt.start;
        psc_next = nxt.psc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            chan_q  <= '0;
            first_q <= 1'b1;
        end else begin
            ctrl_q  <= nxt;
            chan_q  <= chan_n;
            first_q <= first_n;
        end
    end

    // R2: a disabled unit never shows a busy start bit
    p_disabled_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.en |-> !ctrl_q.start);

    // R9: a write that leaves the unit off cannot raise the start bit
    p_no_start_when_off_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_addr && !wr_data[REG_W-1]) |=> !ctrl_q.start);

endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer
    import adc_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             keep,
    input  logic [CNT_W-1:0] target,
    output logic             running,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] tgt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            cnt_q   <= '0;
            tgt_q   <= '0;
        end else if (load) begin
            running <= 1'b1;
            cnt_q   <= '0;
            tgt_q   <= target;
        end else if (!keep) begin
            running <= 1'b0;
            cnt_q   <= '0;
        end else if (running) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    assign last = running && (cnt_q == tgt_q - 1'b1);

    // R3: the count never passes the latched conversion length
    p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
        running |-> (cnt_q < tgt_q));

endmodule

// File: rtl/adc_seq_out.sv
module adc_seq_out
    import adc_seq_pkg::*;
#(
    parameter int SAMPLE_W = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_go,
    input  logic [CHAN_W-1:0]   chan,
    input  logic                complete,
    input  logic [SAMPLE_W-1:0] sample_in,
    output logic                trig_out,
    output logic [CHAN_W-1:0]   trig_chan,
    output logic                done,
    output logic [SAMPLE_W-1:0] result
);

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_out  <= 1'b0;
            trig_chan <= '0;
            done      <= 1'b0;
            result    <= '0;
        end else begin
            trig_out <= start_go;
            done     <= complete;
            if (start_go) trig_chan <= chan;
            if (complete) result    <= sample_in;
        end
    end

    // R7: trigger-out is a single-cycle pulse
    p_trig_single_r7: assert property (@(posedge clk) disable iff (rst)
        trig_out |=> !trig_out);

    // R5: completion is a single-cycle pulse
    p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int SAMPLE_W = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic                wr_addr,
    input  logic [7:0]          wr_data,
    input  logic                trig_in,
    input  logic                irq_ack,
    input  logic [SAMPLE_W-1:0] sample_in,
    output logic [7:0]          ctrl_o,
    output logic [3:0]          chan_o,
    output logic                trig_out,
    output logic [3:0]          trig_chan,
    output logic                done,
    output logic [SAMPLE_W-1:0] result,
    output logic                irq
);

    ctrl_t             ctrl_q;
    logic [CHAN_W-1:0] chan_q;
    logic              start_go, complete, keep_run, long_conv;
    logic [PSC_W-1:0]  psc_next;
    logic              running, conv_last;
    logic [CNT_W-1:0]  target;

    adc_seq_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .trig_in   (trig_in),
        .irq_ack   (irq_ack),
        .conv_last (conv_last),
        .ctrl_q    (ctrl_q),
        .chan_q    (chan_q),
        .start_go  (start_go),
        .complete  (complete),
        .keep_run  (keep_run),
        .long_conv (long_conv),
        .psc_next  (psc_next)
    );

    assign target = conv_cycles(long_conv, psc_next);

    adc_seq_timer u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (start_go),
        .keep    (keep_run),
        .target  (target),
        .running (running),
        .last    (conv_last)
    );

    adc_seq_out #(.SAMPLE_W(SAMPLE_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .start_go  (start_go),
        .chan      (chan_q),
        .complete  (complete),
        .sample_in (sample_in),
        .trig_out  (trig_out),
        .trig_chan (trig_chan),
        .done      (done),
        .result    (result)
    );

    assign ctrl_o = ctrl_q;
    assign chan_o = chan_q;
    assign irq    = ctrl_q.flag && ctrl_q.ie;

    // R1: the register start bit and the timer agree on busy
    p_busy_tracks_timer_r1: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.start == running);

    // R5: a completion leaves the flag set and the start bit clear
    p_done_state_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> (ctrl_q.flag && !ctrl_q.start));

endmodule

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, wr_addr = 1'b0, trig_in = 1'b0, irq_ack = 1'b0;
    logic [7:0] wr_data = '0;
    logic [9:0] sample_in = '0;
    logic [7:0] ctrl_o;
    logic [3:0] chan_o, trig_chan;
    logic       trig_out, done, irq;
    logic [9:0] result;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    adc_seq_ctrl u_adc_seq_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .trig_in(trig_in), .irq_ack(irq_ack), .sample_in(sample_in),
        .ctrl_o(ctrl_o), .chan_o(chan_o), .trig_out(trig_out), .trig_chan(trig_chan),
        .done(done), .result(result), .irq(irq)
    );

    // divider field, channel, sample, expected first and later lengths (R3, R4)
    localparam int NV = 5;
    localparam int V_PSC  [NV] = '{0, 1, 2, 3, 5};
    localparam int V_CHAN [NV] = '{3, 9, 15, 0, 6};
    localparam int V_SMP  [NV] = '{10'h155, 10'h2AA, 10'h3FF, 10'h001, 10'h200};
    localparam int V_FIRST[NV] = '{50, 50, 100, 200, 800};
    localparam int V_LATER[NV] = '{26, 26, 52, 104, 416};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mk(input bit en, input bit st, input bit at,
                                      input bit fl, input bit ie, input int psc);
        return {en, st, at, fl, ie, 3'(psc)};
    endfunction

    task automatic wr(input logic a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic measure(output int n);
        n = 0;
        while (ctrl_o[6] && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int n, m;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(ctrl_o == 8'h00, "R10 ctrl", ctrl_o, 0);
        chk(chan_o == 4'h0 && !trig_out && !done && !irq, "R10 outputs",
            {chan_o, trig_out, done, irq}, 0);
        rst = 1'b0;
        @(negedge clk);

        // Vector walk: R3, R4, R5, R7
        for (int i = 0; i < NV; i++) begin
            wr(1'b0, mk(0, 0, 0, 1, 0, 0));
            wr(1'b1, 8'(V_CHAN[i]));
            sample_in = 10'(V_SMP[i]);
            wr(1'b0, mk(1, 1, 0, 0, 0, V_PSC[i]));
            chk(trig_out == 1'b1, "R7 pulse", trig_out, 1);
            chk(trig_chan == 4'(V_CHAN[i]), "R7 channel", trig_chan, V_CHAN[i]);
            measure(n);
            chk(n == V_FIRST[i], "R4 first length", n, V_FIRST[i]);
            chk(done == 1'b1 && ctrl_o[4], "R5 done/flag", {done, ctrl_o[4]}, 3);
            chk(result == 10'(V_SMP[i]), "R5 result", result, V_SMP[i]);
            wr(1'b0, mk(1, 0, 0, 1, 0, V_PSC[i]));
            chk(ctrl_o[4] == 1'b0, "R8 write-one clear", ctrl_o[4], 0);
            wr(1'b0, mk(1, 1, 0, 0, 0, V_PSC[i]));
            measure(n);
            chk(n == V_LATER[i], "R3 later length", n, V_LATER[i]);
        end

        // R1: writing start=0 mid-conversion is ignored
        wr(1'b0, mk(0, 0, 0, 1, 0, 1));
        wr(1'b0, mk(1, 1, 0, 0, 0, 1));
        repeat (10) @(negedge clk);
        wr(1'b0, mk(1, 0, 0, 0, 0, 1));
        chk(ctrl_o[6] == 1'b1, "R1 start held", ctrl_o[6], 1);
        measure(m);
        chk(11 + m == 50, "R1 full length", 11 + m, 50);

        // R2: disable aborts
        wr(1'b0, mk(1, 0, 0, 1, 0, 1));
        wr(1'b0, mk(1, 1, 0, 0, 0, 1));
        repeat (5) @(negedge clk);
        wr(1'b0, mk(0, 0, 0, 0, 0, 1));
        chk(ctrl_o[6] == 1'b0, "R2 start cleared", ctrl_o[6], 0);
        n = 0;
        repeat (100) begin
            if (done) n++;
            @(negedge clk);
        end
        chk(n == 0 && !ctrl_o[4], "R2 no completion", n, 0);

        // R9: start while disabled is ignored
        wr(1'b0, mk(0, 1, 0, 0, 0, 1));
        chk(ctrl_o[6] == 1'b0, "R9 start off", ctrl_o[6], 0);

        // R6: auto-trigger
        wr(1'b0, mk(1, 0, 1, 0, 0, 1));
        trig_in = 1'b1;
        @(negedge clk);
        trig_in = 1'b0;
        chk(ctrl_o[6] == 1'b1 && trig_out, "R6 trigger start", {ctrl_o[6], trig_out}, 3);
        measure(n);
        chk(n == 50, "R6 first length", n, 50);
        wr(1'b0, mk(1, 0, 0, 1, 0, 1));
        trig_in = 1'b1;
        @(negedge clk);
        trig_in = 1'b0;
        chk(ctrl_o[6] == 1'b0 && !trig_out, "R6 trigger ignored", {ctrl_o[6], trig_out}, 0);

        // R8: interrupt gating and acknowledge
        wr(1'b0, mk(1, 1, 0, 0, 1, 1));
        measure(n);
        chk(irq == 1'b1, "R8 irq set", irq, 1);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        chk(irq == 1'b0 && !ctrl_o[4], "R8 ack clears", {irq, ctrl_o[4]}, 0);

        // R8: clear write on the completion edge loses to the completion
        wr(1'b0, mk(1, 1, 0, 0, 1, 1));
        repeat (25) @(negedge clk);
        wr(1'b0, mk(1, 0, 0, 1, 1, 1));
        chk(done && ctrl_o[4] && !ctrl_o[6], "R8 collision flag",
            {done, ctrl_o[4], ctrl_o[6]}, 6);

        // R2: disable on the completion edge discards it
        wr(1'b0, mk(1, 0, 0, 1, 1, 1));
        wr(1'b0, mk(1, 1, 0, 0, 1, 1));
        repeat (25) @(negedge clk);
        wr(1'b0, mk(0, 0, 0, 0, 1, 1));
        chk(!done && !ctrl_o[4] && !ctrl_o[6], "R2 collision abort",
            {done, ctrl_o[4], ctrl_o[6]}, 0);

        finish_run();
    end

endmodule